// File: doc/BRIEF.md
# TRS Word-Alignment Framer with Offset Filtering

The framer takes a stream of 10-bit words whose character boundary is not yet known. It looks for the timing reference sequence (TRS) at every one of the ten possible bit phases. The sequence is one character of all ones followed by two characters of all zeros. The framer keeps a stored character offset and uses it to cut realigned 10-bit words out of the stream.

Every recognised TRS flips a horizontal-sync toggle output. The flip comes one cycle before the aligned all-ones character leaves the block. A filter enable input sets how offset changes are handled:
- Filter enabled: a TRS at a new phase is rejected once. The framer flags the rejection with a one-cycle error pulse. The stored offset moves only when the next TRS is also off-phase.
- Filter disabled: every TRS takes effect at once.

An active-low DVB mode input switches the function off. The block then passes the raw input words straight through the same output pipeline and keeps its framing state frozen.

Top module: `trs_framer`

## Requirements
- R1: While reset is held, and after it is released, `aligned_word` is 0, `hsync` is 0 and `sync_err` is 0. The stored offset is 0 and not yet locked.
- R2: The stream is in time order, with bit 0 of each input word received first. A TRS is ten consecutive ones followed by twenty consecutive zeros. It is detected at any of the ten phases within a word.
- R3: `hsync` toggles exactly once for each detected TRS. Call the input word that holds the first TRS bit word t. The toggle happens at the clock edge that samples input word t+3. The aligned all-ones character (3FF) appears on `aligned_word` one cycle after the toggle.
- R4: With `filt_en` low, every detected TRS sets the stored offset to its own phase.
- R5: With `filt_en` high and no rejection pending, a TRS whose phase differs from the stored offset behaves as follows. It toggles `hsync`, leaves the offset unchanged, sets the pending flag and raises `sync_err` in the same cycle as the toggle.
- R6: With `filt_en` high and a rejection pending, a TRS whose phase differs from the stored offset behaves as follows. It sets the offset to its own phase, toggles `hsync`, clears the pending flag and does not raise `sync_err`.
- R7: A TRS whose phase equals the locked stored offset behaves as follows. It toggles `hsync`, clears the pending flag and does not raise `sync_err`.
- R8: The first TRS after reset counts as off-phase even when its phase is 0. With `filt_en` high it is therefore rejected.
- R9: `aligned_word` carries the stream cut at the stored offset. Characters following an accepted TRS emerge in order: 3FF, 000, 000, then the data characters.
- R10: While `dvb_mode_n` is low, no TRS is detected. `hsync`, `sync_err` and the stored offset do not change. `aligned_word` equals the input word sampled two edges earlier.
- R11: `sync_err` is high for one cycle at a time, and only in a cycle where `hsync` toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dvb_mode_n | input | 1 | Active-low DVB pass-through mode; disables framing |
| filt_en | input | 1 | Enables two-step confirmation of offset changes |
| rx_word | input | 10 | Unaligned input word, bit 0 earliest |
| aligned_word | output | 10 | Word cut at the stored offset, or raw pass-through in DVB mode |
| hsync | output | 1 | Toggles once per detected TRS |
| sync_err | output | 1 | One-cycle pulse on a rejected off-phase TRS |

## Verification
A wrong stored offset shows up at the outputs within two cycles of the next accepted TRS. The aligned 3FF/000/000 characters come out scrambled, and the data character behind them comes out scrambled too. A pending flag left stale or set wrongly shows up at the next off-phase TRS. In that case `sync_err` either pulses when it should not or stays silent when it should pulse, and the offset that follows is wrong. Missing or extra toggles show on `hsync` in the exact detection cycle. The toggle is compared against a running expected level every cycle, so any slip is caught on the cycle it happens.

// File: rtl/trs_pkg.sv
// Shared definitions for the TRS framer.
// Assumes a 10-bit character; the TRS is one all-ones character then two all-zeros.
package trs_pkg;
    localparam int unsigned TRS_CHAR_W = 10;
    localparam int unsigned TRS_ZERO_CHARS = 2;

    // Outcome of one cycle's framing decision
    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,
        DEC_MATCH  = 2'd1,
        DEC_REJECT = 2'd2,
        DEC_ACCEPT = 2'd3
    } trs_dec_e;
endpackage

// File: rtl/trs_window.sv
// Sliding search window over the incoming stream.
// Holds the last three words and, together with the current input, looks for
// the TRS at every bit phase of the oldest word. Assumes bit 0 is earliest.
module trs_window #(
    parameter int W = trs_pkg::TRS_CHAR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W-1:0]         rx_word,
    output logic [2*W-1:0]       low_win,
    output logic                 hit,
    output logic [$clog2(W)-1:0] hit_off
);
    localparam int OFF_W = $clog2(W);
    localparam int PAT_W = (1 + trs_pkg::TRS_ZERO_CHARS) * W;
    localparam int WIN_W = PAT_W + W - 1;
    localparam logic [PAT_W-1:0] PATTERN = {{(PAT_W-W){1'b0}}, {W{1'b1}}};

    logic [W-1:0]     prev1, prev2, prev3;
    logic [WIN_W-1:0] win;
    logic [W-1:0]     phase_hit;

    // Shift the word history one character per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev1 <= '0;
            prev2 <= '0;
            prev3 <= '0;
        end else begin
            prev1 <= rx_word;
            prev2 <= prev1;
            prev3 <= prev2;
        end
    end

    assign win     = {rx_word[W-2:0], prev1, prev2, prev3};
    assign low_win = {prev2, prev3};

    // One comparator per bit phase
    generate
        for (genvar k = 0; k < W; k++) begin : g_phase
            assign phase_hit[k] = (win[k +: PAT_W] == PATTERN);
        end
    endgenerate

    // Encode the matching phase (at most one can match)
    always_comb begin
        hit_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (phase_hit[k]) hit_off = OFF_W'(k);
        end
    end

    assign hit = |phase_hit;
endmodule

// File: rtl/trs_offset_ctl.sv
// Offset decision logic with optional confirmation filter.
// Keeps the stored offset, a lock bit and a pending-rejection flag; drives the
// sync toggle and error pulse. Assumes at most one detection per three cycles.
module trs_offset_ctl #(
    parameter int W = trs_pkg::TRS_CHAR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [$clog2(W)-1:0] hit_off,
    input  logic                 filt_en,
    input  logic                 dvb_mode_n,
    output logic [$clog2(W)-1:0] off_q,
    output logic [$clog2(W)-1:0] off_nxt,
    output logic                 hsync,
    output logic                 sync_err
);
    import trs_pkg::*;

    logic     locked;
    logic     pending;
    logic     off_miss;
    trs_dec_e dec;

    // Classify this cycle's detection
    always_comb begin
        off_miss = !locked || (hit_off != off_q);
        if (!hit || !dvb_mode_n)       dec = DEC_NONE;
        else if (!off_miss)            dec = DEC_MATCH;
        else if (!filt_en || pending)  dec = DEC_ACCEPT;
        else                           dec = DEC_REJECT;
    end

    assign off_nxt = (dec == DEC_ACCEPT) ? hit_off : off_q;

    // Update framing state and sync outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= '0;
            locked   <= 1'b0;
            pending  <= 1'b0;
            hsync    <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            off_q    <= off_nxt;
            locked   <= locked || (dec == DEC_ACCEPT);
            if (dec == DEC_REJECT)    pending <= 1'b1;
            else if (dec != DEC_NONE) pending <= 1'b0;
            hsync    <= hsync ^ (dec != DEC_NONE);
            sync_err <= (dec == DEC_REJECT);
        end
    end
endmodule

// File: rtl/trs_align.sv
// Character extraction and two-stage output pipeline.
// Cuts a word from the window at the selected offset, or takes the raw input
// in DVB mode, then delays it so the sync toggle leads the data by one cycle.
module trs_align #(
    parameter int W = trs_pkg::TRS_CHAR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*W-1:0]       low_win,
    input  logic [$clog2(W)-1:0] sel,
    input  logic                 dvb_mode_n,
    input  logic [W-1:0]         rx_word,
    output logic [W-1:0]         aligned_word
);
    logic [W-1:0] stage1;

    // Extract or bypass, then delay one more cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1       <= '0;
            aligned_word <= '0;
        end else begin
            stage1       <= dvb_mode_n ? low_win[sel +: W] : rx_word;
            aligned_word <= stage1;
        end
    end
endmodule

// File: rtl/trs_framer.sv
// TRS word-alignment framer: top level.
// Joins the search window, the offset controller and the output aligner.
// Assumes the input clock runs at the character rate.
module trs_framer #(
    parameter int W = trs_pkg::TRS_CHAR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dvb_mode_n,
    input  logic         filt_en,
    input  logic [W-1:0] rx_word,
    output logic [W-1:0] aligned_word,
    output logic         hsync,
    output logic         sync_err
);
    localparam int OFF_W = $clog2(W);

    logic [2*W-1:0]   low_win;
    logic             hit;
    logic [OFF_W-1:0] hit_off;
    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] off_nxt;

    trs_window #(.W(W)) u_win (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word),
        .low_win(low_win), .hit(hit), .hit_off(hit_off)
    );

    trs_offset_ctl #(.W(W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .hit(hit), .hit_off(hit_off),
        .filt_en(filt_en), .dvb_mode_n(dvb_mode_n),
        .off_q(off_q), .off_nxt(off_nxt), .hsync(hsync), .sync_err(sync_err)
    );

    trs_align #(.W(W)) u_aln (
        .clk(clk), .rst_n(rst_n), .low_win(low_win), .sel(off_nxt),
        .dvb_mode_n(dvb_mode_n), .rx_word(rx_word), .aligned_word(aligned_word)
    );
endmodule

// File: rtl/trs_framer_chk.sv
// Property checker for the TRS framer, attached by bind.
module trs_framer_chk #(
    parameter int W = trs_pkg::TRS_CHAR_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dvb_mode_n,
    input logic                 filt_en,
    input logic [W-1:0]         rx_word,
    input logic [W-1:0]         aligned_word,
    input logic                 hsync,
    input logic                 sync_err,
    input logic [$clog2(W)-1:0] off_q
);
    p_err_with_toggle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> (hsync != $past(hsync)));

    p_err_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err);

    p_err_needs_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> ($past(filt_en) && $past(dvb_mode_n)));

    p_off_moves_on_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q != $past(off_q)) |-> (hsync != $past(hsync)));

    p_dvb_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dvb_mode_n) |-> ($stable(hsync) && !sync_err && $stable(off_q)));

    p_dvb_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(dvb_mode_n, 2))
            |-> (aligned_word == $past(rx_word, 2)));
endmodule

bind trs_framer trs_framer_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dvb_mode_n(dvb_mode_n), .filt_en(filt_en),
    .rx_word(rx_word), .aligned_word(aligned_word), .hsync(hsync),
    .sync_err(sync_err), .off_q(off_q)
);

// File: tb/sim_trs_framer.sv
// Scoreboard bench: the driver builds a bit stream, models the framing rules
// and queues expected events; the monitor pops and compares each cycle.
module sim_trs_framer;
    localparam int W  = 10;
    localparam int NW = 280;
    localparam int NB = NW * W;
    localparam logic [W-1:0] DATA_CH = 10'h0C6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dvb_mode_n = 1'b1;
    logic         filt_en = 1'b1;
    logic [W-1:0] rx_word = '0;
    logic [W-1:0] aligned_word;
    logic         hsync;
    logic         sync_err;

    always #2 clk = ~clk;

    trs_framer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .dvb_mode_n(dvb_mode_n), .filt_en(filt_en),
        .rx_word(rx_word), .aligned_word(aligned_word), .hsync(hsync), .sync_err(sync_err)
    );

    typedef struct {
        int           cyc;
        bit           is_tgl;
        bit           err;
        logic [W-1:0] word;
        string        req;
    } ev_t;

    ev_t  q[$];
    bit   strm[NB];
    int   cyc = 0;
    int   c0 = 0;
    int   checks = 0;
    int   errors = 0;
    bit   run = 1'b0;
    bit   done = 1'b0;
    logic exp_hs = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] word_at(int n);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = strm[n*W + i];
        return r;
    endfunction

    function automatic bit filt_for(int d);
        return (d < 50) || (d >= 90);
    endfunction

    function automatic bit dvb_word(int n);
        return (n >= 210) && (n < 240);
    endfunction

    task automatic check_w(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic check_b(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic push_ev(int c, bit t, bit e, logic [W-1:0] w, string req);
        ev_t ev;
        ev.cyc = c; ev.is_tgl = t; ev.err = e; ev.word = w; ev.req = req;
        q.push_back(ev);
    endtask

    task automatic put_trs(int p);
        for (int i = 0; i < W; i++)     strm[p + i] = 1'b1;
        for (int i = W; i < 3 * W; i++) strm[p + i] = 1'b0;
        for (int i = 0; i < W; i++)     strm[p + 3*W + i] = DATA_CH[i];
    endtask

    // Monitor: compare outputs against the scoreboard every cycle
    always @(negedge clk) begin
        bit  e_err;
        int  r;
        ev_t e;
        if (run && !done) begin
            e_err = 1'b0;
            r = cyc - c0;
            while (q.size() > 0 && q[0].cyc == r) begin
                e = q.pop_front();
                if (e.is_tgl) begin
                    exp_hs = ~exp_hs;
                    e_err  = e.err;
                end else begin
                    check_w(e.req, aligned_word, e.word);
                end
            end
            check_b("R3/R10 hsync toggle", hsync, exp_hs);
            check_b("R11 sync_err pulse", sync_err, e_err);
        end
    end

    // Driver: build stream, model the rules, then play the words
    initial begin
        int  pos[12];
        int  m_off;
        bit  m_pend;
        bit  m_lock;
        pos = '{100, 300, 503, 707, 907, 1102, 1305, 1509, 1705, 1901, 2203, 2605};
        for (int i = 0; i < NB; i++) strm[i] = bit'(i % 2);
        foreach (pos[i]) put_trs(pos[i]);

        m_off = 0; m_pend = 1'b0; m_lock = 1'b0;
        foreach (pos[i]) begin
            int    t0;
            int    k;
            int    e;
            bit    miss;
            bit    f;
            string tag;
            t0 = pos[i] / W;
            k  = pos[i] % W;
            e  = t0 + 4;
            if (dvb_word(t0 + 3)) begin
                // R10: raw words pass through with two cycles of delay
                for (int n = t0 + 4; n < t0 + 8; n++)
                    push_ev(n + 2, 1'b0, 1'b0, word_at(n), "R10 DVB pass-through");
            end else begin
                f    = filt_for(t0 + 3);
                miss = !m_lock || (k != m_off);
                if (!miss) begin
                    tag = "R7 match"; m_pend = 1'b0;
                    push_ev(e, 1'b1, 1'b0, '0, tag);
                end else if (!f || m_pend) begin
                    tag = f ? "R6 confirmed" : "R4 unfiltered";
                    m_off = k; m_lock = 1'b1; m_pend = 1'b0;
                    push_ev(e, 1'b1, 1'b0, '0, tag);
                end else begin
                    tag = m_lock ? "R5 reject" : "R8 first after reset";
                    m_pend = 1'b1;
                    push_ev(e, 1'b1, 1'b1, '0, tag);
                end
                if (!miss || !f || tag == "R6 confirmed") begin
                    push_ev(e + 1, 1'b0, 1'b0, {W{1'b1}}, "R2 aligned 3FF");
                    push_ev(e + 2, 1'b0, 1'b0, '0, "R9 first zero char");
                    push_ev(e + 3, 1'b0, 1'b0, '0, "R9 second zero char");
                    push_ev(e + 4, 1'b0, 1'b0, DATA_CH, "R9 data at offset");
                end
            end
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check_w("R1 reset aligned_word", aligned_word, '0);
        check_b("R1 reset hsync", hsync, 1'b0);
        check_b("R1 reset sync_err", sync_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_b("R1 after release hsync", hsync, 1'b0);

        for (int n = 0; n < NW; n++) begin
            @(negedge clk);
            if (n == 0) begin
                c0  = cyc;
                run = 1'b1;
            end
            rx_word    = word_at(n);
            filt_en    = filt_for(n);
            dvb_mode_n = !dvb_word(n);
        end
        repeat (8) @(negedge clk);
        check_b("R3 all events consumed", q.size() == 0, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule